// File: doc/BRIEF.md
# Single-Precision Sign Injection Unit

This unit forms a floating-point result whose magnitude is taken from operand one and whose sign is derived from operand two. A 3-bit mode field picks the sign rule: copy operand two's sign, copy its inverse, or XOR the two operand signs. Before any sign is read or applied, each operand is cleaned of subnormals. An operand with a zero exponent field becomes a zero that keeps its own sign. As a result, a subnormal magnitude never appears at the output.

Operands enter on a valid/ready stream, and the result leaves on a second valid/ready stream through a single register stage. The stage accepts a new operand pair when it is empty, or when its current result is being taken in the same cycle. A stalled result holds still until the consumer raises `out_ready`. No exception flags are raised. NaN inputs are not canonicalized, so a NaN payload passes through and only its sign bit may change. Mode codes outside the three defined ones return the cleaned operand one unchanged and raise an illegal-mode flag alongside that result.

Top module: `sgnj_unit`

## Requirements
- R1: Mode 3'b000 gives a result whose bit 31 equals bit 31 of operand two and whose bits 30:0 equal bits 30:0 of the cleaned operand one.
- R2: Mode 3'b001 gives bit 31 equal to the inverse of operand two's bit 31, with bits 30:0 from the cleaned operand one.
- R3: Mode 3'b010 gives bit 31 equal to the XOR of both operands' bit 31, with bits 30:0 from the cleaned operand one.
- R4: An operand one whose exponent field (bits 30:23) is zero contributes a magnitude of zero, so no accepted result has a zero exponent with a non-zero fraction.
- R5: An operand two whose exponent field is zero still supplies its own bit 31 as its sign.
- R6: A NaN operand one (exponent all ones, non-zero fraction) keeps its fraction payload bit for bit. Only bit 31 follows the mode.
- R7: Mode codes 3'b011 to 3'b111 return the cleaned operand one with its own sign and set `out_illegal`. The three defined modes clear `out_illegal`.
- R8: A pair accepted on a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` high after that same edge. Results leave in acceptance order.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_illegal` hold their values and no new pair is accepted.
- R10: `in_ready` is high exactly when the stage is empty or `out_ready` is high.
- R11: A synchronous reset (`rst` high at a clock edge) clears `out_valid`, `out_data` and `out_illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take a pair this cycle |
| in_a | input | 32 | Operand one, magnitude source |
| in_b | input | 32 | Operand two, sign source |
| in_mode | input | 3 | Sign rule select |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result word |
| out_illegal | output | 1 | Result came from an undefined mode code |

## Verification
The hardest case to reach from the ports is a producer that keeps offering a new pair while the output is stalled, followed by a release in which a result leaves and a new pair enters on the same edge. The bench holds `out_ready` low with `in_valid` high and checks that the result stays stable and that `in_ready` stays low. It then streams a long random run against a pseudo-random `out_ready` pattern, and the scoreboard confirms that no item is lost, duplicated or reordered.

// File: rtl/sgnj_pkg.sv
package sgnj_pkg;
  // sign rule encodings; the code values are part of the instruction decode
  typedef enum logic [2:0] {
    SJ_COPY = 3'b000,
    SJ_NEG  = 3'b001,
    SJ_XOR  = 3'b010
  } sj_mode_e;

  localparam int SJ_MODE_W = 3;
endpackage

// File: rtl/sgnj_flush.sv
// Replaces a zero-exponent operand with a zero of the same sign.
module sgnj_flush #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  logic [EXP_W-1:0] exp_f;

  always_comb begin
    exp_f = word_i[W-2 -: EXP_W];
    if (exp_f == '0) word_o = {word_i[W-1], {(W-1){1'b0}}};
    else             word_o = word_i;
  end
endmodule

// File: rtl/sgnj_sign_sel.sv
// Chooses the result sign from the two cleaned operand signs.
module sgnj_sign_sel
  import sgnj_pkg::*;
(
  input  logic                 sign_a,
  input  logic                 sign_b,
  input  logic [SJ_MODE_W-1:0] mode,
  output logic                 sign_o,
  output logic                 illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    case (mode)
      SJ_COPY: sign_o = sign_b;
      SJ_NEG:  sign_o = ~sign_b;
      SJ_XOR:  sign_o = sign_a ^ sign_b;
      default: begin
        sign_o    = sign_a;
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sgnj_stage.sv
// One-entry valid/ready register slice.
module sgnj_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         s_flag,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         m_flag
);
  assign s_ready = ~m_valid | m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_flag  <= 1'b0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) begin
        m_data <= s_data;
        m_flag <= s_flag;
      end
    end
  end
endmodule

// File: rtl/sgnj_unit.sv
module sgnj_unit
  import sgnj_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic [SJ_MODE_W-1:0] in_mode,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data,
  output logic                 out_illegal
);
  localparam int N_OPS = 2;

  logic [W-1:0] raw_ops   [N_OPS];
  logic [W-1:0] clean_ops [N_OPS];
  logic         res_sign;
  logic         res_ill;
  logic [W-1:0] res_word;

  assign raw_ops[0] = in_a;
  assign raw_ops[1] = in_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_clean
    sgnj_flush #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_flush (
      .word_i (raw_ops[g]),
      .word_o (clean_ops[g])
    );
  end

  sgnj_sign_sel u_sign (
    .sign_a    (clean_ops[0][W-1]),
    .sign_b    (clean_ops[1][W-1]),
    .mode      (in_mode),
    .sign_o    (res_sign),
    .illegal_o (res_ill)
  );

  assign res_word = {res_sign, clean_ops[0][W-2:0]};

  sgnj_stage #(.W(W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (res_word),
    .s_flag  (res_ill),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data),
    .m_flag  (out_illegal)
  );
endmodule

// File: rtl/sgnj_unit_chk.sv
module sgnj_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [2:0]   in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_illegal
);
  // R1
  copy_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode == 3'b000) |=> (out_data[W-1] == $past(in_b[W-1])));
  // R3
  xor_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode == 3'b010) |=> (out_data[W-1] == ($past(in_a[W-1]) ^ $past(in_b[W-1]))));
  // R4
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[W-2 -: EXP_W] == '0) |-> (out_data[MAN_W-1:0] == '0));
  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_illegal == ($past(in_mode) > 3'b010)));
  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));
  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_illegal));
endmodule

bind sgnj_unit sgnj_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .in_mode     (in_mode),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/tb_sgnj_unit.sv
`timescale 1ns/1ps
module tb_sgnj_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;     // 0: always ready, 1: pseudo-random, 2: stalled
  logic [15:0] lfsr = 16'hACE1;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sgnj_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b, logic [2:0] m);
    logic [31:0] fa, fb;
    logic s;
    fa = (a[30:23] == 8'd0) ? {a[31], 31'd0} : a;
    fb = (b[30:23] == 8'd0) ? {b[31], 31'd0} : b;
    case (m)
      3'b000:  s = fb[31];
      3'b001:  s = ~fb[31];
      3'b010:  s = fa[31] ^ fb[31];
      default: s = fa[31];
    endcase
    return {(m > 3'b010), s, fa[30:0]};
  endfunction

  task automatic check(string tag, logic [32:0] act, logic [32:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // ready pattern, updated at the falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= lfsr[0] | lfsr[3];
      default: out_ready <= 1'b0;
    endcase
  end

  // monitor: a result with out_ready high leaves at the next rising edge
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 actual=unexpected %h expected=none", out_data);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {out_illegal, out_data}, e);
      end
    end
  end

  task automatic send(logic [31:0] a, logic [31:0] b, logic [2:0] m, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_mode = m;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(a, b, m));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state, R10 ready when empty
    check("R11", {out_illegal, out_valid, out_data}, 34'd0);
    check("R10", {32'd0, in_ready}, 33'd1);

    // R8: latency observed directly (monitor has popped nothing yet)
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h3fc00000; in_b = 32'h80000000; in_mode = 3'b000;
    exp_q.push_back(model(32'h3fc00000, 32'h80000000, 3'b000));
    tag_q.push_back("R1");
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {32'd0, out_valid}, 33'd1);
    drain();

    send(32'h3f800000, 32'h00000000, 3'b000, "R1");
    send(32'hbf800000, 32'h00000000, 3'b001, "R2");
    send(32'h40490fdb, 32'hc0000000, 3'b001, "R2");
    send(32'hc0000000, 32'hc1200000, 3'b010, "R3");
    send(32'h40000000, 32'h80000000, 3'b010, "R3");
    send(32'h00400000, 32'h80000000, 3'b000, "R4");
    send(32'h80000001, 32'h00000000, 3'b010, "R4");
    send(32'h3f800000, 32'h80000005, 3'b000, "R5");
    send(32'h3f800000, 32'h007fffff, 3'b001, "R5");
    send(32'h7fc01234, 32'h80000000, 3'b000, "R6");
    send(32'hff800001, 32'h00000000, 3'b001, "R6");
    for (int m = 3; m < 8; m++) send(32'hc0a00000, 32'h00000000, m[2:0], "R7");
    send(32'h00000007, 32'h80000000, 3'b101, "R7");
    drain();

    // R9: stall the output with a new pair waiting at the input
    ready_mode = 2;
    send(32'h41200000, 32'h80000000, 3'b000, "R9");
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h42000000; in_b = 32'h00000000; in_mode = 3'b010;
    #1;
    held = out_data;
    repeat (5) @(negedge clk);
    #1;
    check("R9", {out_valid, out_data}, {1'b1, held});
    check("R10", {32'd0, in_ready}, 33'd0);
    exp_q.push_back(model(32'h42000000, 32'h00000000, 3'b010));
    tag_q.push_back("R9");
    ready_mode = 0;
    @(negedge clk); #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R8 ordering under random back-pressure
    ready_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      logic [2:0] m;
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) a[30:23] = 8'd0;
      if (i % 11 == 0) b[30:23] = 8'd0;
      m = (i % 13 == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
      send(a, b, m, "R8");
    end
    ready_mode = 0;
    drain();

    // R11: reset while a result is held
    ready_mode = 2;
    send(32'h3f800000, 32'h80000000, 3'b000, "R11");
    exp_q.delete(); tag_q.delete();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11", {out_illegal, out_valid, out_data}, 34'd0);
    ready_mode = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule